// File: doc/BRIEF.md
# GPIO and Interrupt Expander on a Memory-Mapped Bus

This block widens a host's pin count through a plain parallel register bus. Every pin is fixed, at elaboration, as an input or an output. Outputs come from writable latches that power up to a chosen pattern. Inputs pass through a two-stage synchronizer and are read back from the same registers that hold the outputs. GPIO number g lives in register `REG_START + g / REG_W`, at bit `g % REG_W`.

Up to sixteen interrupt lines are synchronized, and a rising edge on any of them latches a pending bit. All pending bits are visible in one status register. There is no per-source mask, so a single registered summary line rises whenever anything is pending. The host clears every pending bit at once by writing a fixed pattern to that same status register. The pattern is all ones, or all zeros when the inversion parameter is set. After a clearing write the summary line is forced low for one cycle. An edge-triggered host therefore sees a fresh rising edge if a source is still or newly pending.

The bus has no flow control: an access completes in the cycle it is presented. Read data is combinational from the address, and a write takes effect at the next clock edge. No back-pressure exists, so the pins stay plain control signals.

Top module: `gpio_irq_expander`

## Requirements
- R1: While reset is asserted and right after it, `pin_out` equals `INIT_MAP & DIR_MAP`, `irq_out` is 0 and no interrupt is pending.
- R2: Register index N decodes at byte address N<<1 when `BUS_SPACING` is 16 and at N<<2 when it is 32. An address whose low shift bits are not zero is unmapped.
- R3: A bus write to GPIO register `REG_START + k` sets every output pin g = k*REG_W + b to write-data bit b at the next clock edge. Data bits at or above `REG_W` are ignored.
- R4: Pins whose `DIR_MAP` bit is 0 are inputs. Writes to their bits change nothing, and their `pin_out` bit stays 0.
- R5: Reading a GPIO register returns the latched value for output bits. For input bits it returns `pin_in` delayed by two clock edges. Bits for pins beyond `NUM_PINS`, and bits at or above `REG_W`, read 0.
- R6: A read of an unmapped address returns 0. A write to one changes no output and no pending bit.
- R7: A rising edge on `irq_src[i]` sets pending bit i on the third clock edge after the line is first sampled high. The bit stays set until cleared, and a line held high does not set it again. Reading the status register at index `ACK_INDEX` returns the pending bits in data bits [NUM_IRQ-1:0], with 0 above them.
- R8: With no clearing write in that cycle, any pending bit drives `irq_out` high at the next clock edge. No source can be masked.
- R9: Writing exactly 16'hFFFF to the status register (16'h0000 when `ACK_INVERT` is 1) clears all pending bits. Any other value written there has no effect.
- R10: A source edge that would set its pending bit in the same cycle as a clearing write leaves that bit set.
- R11: `irq_out` is 0 in the cycle after a clearing write. It rises again one cycle later if any bit is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| pin_in | input | NUM_PINS | Pin levels from the board (used on input pins) |
| pin_out | output | NUM_PINS | Output latches (0 on input pins) |
| irq_src | input | NUM_IRQ | Asynchronous interrupt source lines |
| irq_out | output | 1 | Summary interrupt, rising-edge meaningful |

## Verification
The bank registers are written with all-ones patterns and with data whose upper byte is set. These patterns separate the output bits from the protected input bits and from data bits above the register width. Aligned addresses outside the map and misaligned addresses are then accessed to separate a correct decode from one that ignores the spacing bits. For interrupts, the bench uses a single edge, a line held high across a clear, and several sources at once. It also writes non-matching values to the status register and places a new edge in the very cycle of a clear. Together these separate edge latching from level latching, a full-pattern compare from a partial one, and set-priority from clear-priority. A reference model compares `pin_out` and `irq_out` on every clock.

// File: rtl/exp_pkg.sv
package exp_pkg;

  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_BANK = 2'd1,
    HIT_ACK  = 2'd2
  } hit_e;

  // byte-address shift for a given register spacing in bits
  function automatic int spacing_shift(input int spacing);
    return (spacing == 32) ? 2 : 1;
  endfunction

endpackage

// File: rtl/exp_addr_decode.sv
module exp_addr_decode
  import exp_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BUS_SPACING = 32,
  parameter int REG_START   = 1,
  parameter int NREG        = 3,
  parameter int ACK_INDEX   = 5,
  parameter int BANK_W      = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_e              kind,
  output logic [BANK_W-1:0] bank
);
  localparam int SHIFT = spacing_shift(BUS_SPACING);

  logic              aligned;
  logic [ADDR_W-1:0] index;
  int                idx_i;

  assign aligned = (addr[SHIFT-1:0] == '0);
  assign index   = addr >> SHIFT;
  assign idx_i   = int'(index);

  always_comb begin
    kind = HIT_NONE;
    bank = '0;
    if (aligned) begin
      if (idx_i == ACK_INDEX) begin
        kind = HIT_ACK;
      end else if (idx_i >= REG_START && idx_i < REG_START + NREG) begin
        kind = HIT_BANK;
        bank = BANK_W'(idx_i - REG_START);
      end
    end
  end
endmodule

// File: rtl/exp_sync.sv
module exp_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/exp_out_bank.sv
module exp_out_bank #(
  parameter int                  REG_W    = 8,
  parameter int                  NUM_PINS = 20,
  parameter int                  BANK_W   = 2,
  parameter logic [NUM_PINS-1:0] DIR_MAP  = '0,
  parameter logic [NUM_PINS-1:0] INIT_MAP = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [BANK_W-1:0]   wr_bank,
  input  logic [REG_W-1:0]    wr_data,
  output logic [NUM_PINS-1:0] pin_out
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    localparam int BK = g / REG_W;
    localparam int BT = g % REG_W;
    if (DIR_MAP[g]) begin : g_drv
      logic bit_q;
      always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= INIT_MAP[g];
        else if (wr_en && wr_bank == BANK_W'(BK)) bit_q <= wr_data[BT];
      end
      assign pin_out[g] = bit_q;
    end else begin : g_sense
      assign pin_out[g] = 1'b0;
    end
  end

  AST_OUT_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pin_out)); // R3
  AST_INPUT_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~DIR_MAP) == '0); // R4
endmodule

// File: rtl/exp_irq_latch.sv
module exp_irq_latch #(
  parameter int NUM_IRQ = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] src_sync,
  input  logic               ack_clear,
  output logic [NUM_IRQ-1:0] pend,
  output logic               irq_out
);
  logic [NUM_IRQ-1:0] prev;
  logic [NUM_IRQ-1:0] rise;

  assign rise = src_sync & ~prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev    <= '0;
      pend    <= '0;
      irq_out <= 1'b0;
    end else begin
      prev    <= src_sync;
      pend    <= (ack_clear ? '0 : pend) | rise;
      irq_out <= ack_clear ? 1'b0 : (pend != '0);
    end
  end

  AST_EDGE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pend & $past(rise)) == $past(rise))); // R10
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_clear |=> ((pend & $past(pend)) == $past(pend))); // R7
  AST_ACK_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clear && rise == '0) |=> (pend == '0)); // R9
  AST_PENDING_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0 && !ack_clear) |=> irq_out); // R8
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack_clear |=> !irq_out); // R11
endmodule

// File: rtl/gpio_irq_expander.sv
module gpio_irq_expander
  import exp_pkg::*;
#(
  parameter int                  REG_W       = 8,
  parameter int                  BUS_SPACING = 32,
  parameter int                  ADDR_W      = 8,
  parameter int                  NUM_PINS    = 20,
  parameter int                  REG_START   = 1,
  parameter int                  ACK_INDEX   = 5,
  parameter int                  NUM_IRQ     = 12,
  parameter bit                  ACK_INVERT  = 1'b0,
  parameter logic [NUM_PINS-1:0] DIR_MAP     = 20'hF0F0F,
  parameter logic [NUM_PINS-1:0] INIT_MAP    = 20'h500A3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [15:0]         bus_wdata,
  output logic [15:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  input  logic [NUM_IRQ-1:0]  irq_src,
  output logic                irq_out
);
  localparam int          NREG        = (NUM_PINS + REG_W - 1) / REG_W;
  localparam int          BANK_W      = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int          PAD_W       = NREG * REG_W;
  localparam logic [15:0] ACK_PATTERN = ACK_INVERT ? 16'h0000 : 16'hFFFF;

  if (REG_W != 8 && REG_W != 16) begin : g_bad_reg_w
    $error("REG_W must be 8 or 16");
  end
  if (BUS_SPACING != 16 && BUS_SPACING != 32) begin : g_bad_spacing
    $error("BUS_SPACING must be 16 or 32");
  end
  if (NUM_IRQ < 1 || NUM_IRQ > 16) begin : g_bad_irq
    $error("NUM_IRQ must be 1 to 16");
  end

  hit_e                kind;
  logic [BANK_W-1:0]   bank;
  logic                bank_wr;
  logic                ack_clear;
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_IRQ-1:0]  src_sync;
  logic [NUM_IRQ-1:0]  pend;
  logic [NUM_PINS-1:0] view;
  logic [PAD_W-1:0]    view_pad;

  exp_addr_decode #(
    .ADDR_W(ADDR_W), .BUS_SPACING(BUS_SPACING), .REG_START(REG_START),
    .NREG(NREG), .ACK_INDEX(ACK_INDEX), .BANK_W(BANK_W)
  ) i_decode (
    .addr(bus_addr), .kind(kind), .bank(bank)
  );

  assign bank_wr   = bus_sel && bus_wr && (kind == HIT_BANK);
  assign ack_clear = bus_sel && bus_wr && (kind == HIT_ACK) && (bus_wdata == ACK_PATTERN);

  exp_out_bank #(
    .REG_W(REG_W), .NUM_PINS(NUM_PINS), .BANK_W(BANK_W),
    .DIR_MAP(DIR_MAP), .INIT_MAP(INIT_MAP)
  ) i_out (
    .clk(clk), .rst_n(rst_n), .wr_en(bank_wr), .wr_bank(bank),
    .wr_data(bus_wdata[REG_W-1:0]), .pin_out(pin_out)
  );

  exp_sync #(.W(NUM_PINS)) i_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  exp_sync #(.W(NUM_IRQ)) i_irq_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_src), .q(src_sync)
  );

  exp_irq_latch #(.NUM_IRQ(NUM_IRQ)) i_irq (
    .clk(clk), .rst_n(rst_n), .src_sync(src_sync), .ack_clear(ack_clear),
    .pend(pend), .irq_out(irq_out)
  );

  assign view     = (pin_out & DIR_MAP) | (pin_sync & ~DIR_MAP);
  assign view_pad = PAD_W'(view);

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (kind)
        HIT_BANK: bus_rdata = 16'(view_pad[int'(bank)*REG_W +: REG_W]);
        HIT_ACK:  bus_rdata = 16'(pend);
        default:  bus_rdata = '0;
      endcase
    end
  end

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && kind == HIT_NONE) |-> (bus_rdata == '0)); // R6
  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && kind == HIT_ACK) |-> ((bus_rdata >> NUM_IRQ) == '0)); // R7
endmodule

// File: tb/test_gpio_irq_expander.sv
`timescale 1ns/1ps
module test_gpio_irq_expander;
  localparam int                 NP   = 20;
  localparam int                 NI   = 12;
  localparam logic [NP-1:0]      DIR  = 20'hF0F0F;
  localparam logic [NP-1:0]      INIT = 20'h500A3;
  localparam logic [7:0]         A_ACK = 8'd20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic [15:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NI-1:0] irq_src = '0;
  logic          irq_out;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_expander i_gpio_irq_expander (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .irq_src(irq_src), .irq_out(irq_out)
  );

  // reference model
  logic [NP-1:0] m_out;
  logic [NI-1:0] m_pend;
  logic          m_irq;
  logic [NI-1:0] hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out  = INIT & DIR;
      m_pend = '0;
      m_irq  = 1'b0;
      hist   = {NI'(0), NI'(0), NI'(0)};
    end else begin
      bit            clr;
      logic [NI-1:0] rise;
      int            idx;
      clr = 1'b0;
      idx = int'(bus_addr) / 4;
      if (bus_sel && bus_wr && bus_addr[1:0] == 2'b00) begin
        if (idx >= 1 && idx <= 3) begin
          for (int b = 0; b < 8; b++) begin
            int g;
            g = (idx - 1) * 8 + b;
            if (g < NP && DIR[g]) m_out[g] = bus_wdata[b];
          end
        end
        if (idx == 5 && bus_wdata == 16'hFFFF) clr = 1'b1;
      end
      rise   = hist[1] & ~hist[2];
      m_irq  = clr ? 1'b0 : (m_pend != '0);
      m_pend = (clr ? '0 : m_pend) | rise;
      hist.push_front(irq_src);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // every-clock comparison of registered outputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 pin_out vs model", 32'(pin_out), 32'(m_out));
      chk("R8 irq_out vs model", 32'(irq_out), 32'(m_irq));
    end
  end

  function automatic logic [15:0] exp_bank(input int r);
    logic [15:0] v;
    v = '0;
    for (int b = 0; b < 8; b++) begin
      int g;
      g = r * 8 + b;
      if (g < NP) v[b] = DIR[g] ? m_out[g] : pin_in[g];
    end
    return v;
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [15:0] exp, input string tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(tag, 32'(bus_rdata), 32'(exp));
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [NP-1:0] snap;
    idle(3);
    chk("R1 pin_out in reset", 32'(pin_out), 32'(INIT & DIR));
    chk("R1 irq_out in reset", 32'(irq_out), 32'h0);
    rst_n = 1'b1;
    idle(1);
    bus_read(A_ACK, 16'h0000, "R1 nothing pending after reset");

    // input readback
    pin_in = 20'hABCDE;
    idle(3);
    bus_read(8'd4,  exp_bank(0), "R5 bank0 read");
    bus_read(8'd8,  exp_bank(1), "R5 bank1 read");
    bus_read(8'd12, exp_bank(2), "R5 bank2 read upper bits zero");

    // output writes, input bits protected
    bus_write(8'd4, 16'h00FF);
    chk("R4 input bits of bank0 stay low", 32'(pin_out[7:4]), 32'h0);
    chk("R3 output bits of bank0 set", 32'(pin_out[3:0]), 32'hF);
    bus_read(8'd4, exp_bank(0), "R5 bank0 after write");
    bus_write(8'd12, 16'hFF0A);
    chk("R3 bank2 outputs from low data bits", 32'(pin_out[19:16]), 32'hA);
    bus_write(8'd8, 16'h0F50);
    chk("R3 bank1 output nibble", 32'(pin_out[11:8]), 32'h0);
    bus_write(8'd8, 16'h0003);
    chk("R3 bank1 output nibble", 32'(pin_out[11:8]), 32'h3);

    // unmapped and misaligned
    snap = pin_out;
    bus_write(8'd16, 16'hFFFF);
    bus_write(8'd0,  16'hFFFF);
    bus_write(8'd6,  16'h0000);
    bus_write(8'd9,  16'h0000);
    chk("R6 unmapped writes leave pins", 32'(pin_out), 32'(snap));
    bus_read(8'd16, 16'h0000, "R6 unmapped read index4");
    bus_read(8'd0,  16'h0000, "R6 unmapped read index0");
    bus_read(8'd5,  16'h0000, "R2 misaligned read");
    bus_read(8'd22, 16'h0000, "R2 misaligned near status");

    // single edge
    irq_src = 12'h008;
    idle(2);
    chk("R7 not yet pending before third edge", 32'(m_pend), 32'h0);
    idle(2);
    bus_read(A_ACK, 16'h0008, "R7 pending bit 3");
    chk("R8 summary high", 32'(irq_out), 32'h1);
    bus_write(8'd16, 16'hFFFF);
    bus_read(A_ACK, 16'h0008, "R6 unmapped write keeps pending");
    bus_write(A_ACK, 16'hFFFF);
    chk("R11 summary low after clear", 32'(irq_out), 32'h0);
    idle(4);
    bus_read(A_ACK, 16'h0000, "R7 held level does not re-set");
    chk("R9 summary stays low", 32'(irq_out), 32'h0);

    // non-matching acknowledge values
    irq_src = 12'h009;
    idle(4);
    bus_write(A_ACK, 16'h0FFF);
    bus_write(A_ACK, 16'h00FF);
    bus_write(A_ACK, 16'h0000);
    bus_read(A_ACK, 16'h0001, "R9 partial pattern ignored");
    chk("R8 summary still high", 32'(irq_out), 32'h1);

    // edge meeting the clear in the same cycle
    irq_src = 12'h029;
    idle(2);
    bus_write(A_ACK, 16'hFFFF);
    chk("R11 low in cycle after clear", 32'(irq_out), 32'h0);
    idle(1);
    chk("R11 re-rises with bit still pending", 32'(irq_out), 32'h1);
    bus_read(A_ACK, 16'h0020, "R10 same-cycle edge survives clear");

    // several sources together
    irq_src = 12'h000;
    idle(3);
    bus_write(A_ACK, 16'hFFFF);
    irq_src = 12'hC40;
    idle(4);
    bus_read(A_ACK, 16'h0C40, "R8 several sources unmasked");
    bus_write(A_ACK, 16'hFFFF);
    idle(2);
    bus_read(A_ACK, 16'h0000, "R9 all cleared");
    chk("R9 summary low", 32'(irq_out), 32'h0);

    // late input change readback
    pin_in = 20'h5A3C1;
    idle(1);
    bus_read(8'd8, {8'h0, 4'(20'hABCDE >> 12), 4'h3}, "R5 two-edge input delay");
    idle(2);
    bus_read(8'd8, exp_bank(1), "R5 input after sync");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule